// File: doc/BRIEF.md
# Interrupt Level Router with Wake Detect

The router gathers six interrupt request lines, four from on-chip peripherals and two from external pins, and drives each onto one of eight interrupt output levels. Every request line has its own 3-bit level register. An output level is high while any request mapped to it is high. Several requests may share a level, and a level may have no request mapped to it. Operation is level sensitive. Peripheral lines pass through one register stage. External pins pass through a two-flop synchronizer.

A handler that serves a shared level reads a raw status word to find which requests are active. The raw status word shows the registered request lines and ignores the level mapping. A separate wake detector watches the two synchronized external lines. It raises a request to a low-power controller whenever an unmasked line sits at its programmed active level. A word-addressed read/write port with a combinational read path configures the block.

Top module: `ilr_top`

## Requirements
- R1: `irq_lvl[n]` is high exactly when at least one registered request whose level register holds n is high. Several requests may share a level. A level with no active request stays low.
- R2: A peripheral request reaches `irq_lvl` one clock after it is sampled. There is no combinational path from `irq_periph` to `irq_lvl`.
- R3: An external request reaches `irq_lvl` two clocks after it is sampled, through a two-flop synchronizer.
- R4: The level registers sit at word addresses 0 to 5. Addresses 0 to 3 serve peripheral lines 0 to 3, and addresses 4 and 5 serve external lines 0 and 1. Each register keeps only `cfg_wdata[2:0]`, reads back zero above bit 2, and resets to 0.
- R5: Address 6 reads the raw status. Bits 3:0 are the registered peripheral lines and bits 17:16 are the synchronized external lines. All other bits are zero, and the value does not depend on the level registers.
- R6: Address 7 holds the wake mask in bits 1:0, where 1 means masked. It resets to 2'b11. Address 8 holds the wake polarity in bits 1:0, where 1 means active high. It resets to 2'b11.
- R7: `wake_req` is high exactly when some unmasked synchronized external line equals its polarity bit. It follows the synchronizer and configuration with no added register.
- R8: `wake_req` does not depend on the level registers. An external line wakes the system whatever level it is mapped to.
- R9: Writes to address 6 and to unmapped addresses 9 to 15 change no state. Unmapped addresses read as zero.
- R10: After reset, `irq_lvl` is all zero, `wake_req` is low and the raw status reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_periph | input | 4 | Peripheral interrupt requests |
| ext_irq | input | 2 | External interrupt pins, asynchronous |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational from address |
| irq_lvl | output | 8 | Interrupt output levels |
| wake_req | output | 1 | Wake request to low-power controller |

## Verification
The bench targets these corner cases:
- **Shared and empty levels.** Two requests share one level, and levels 0 and 7 are left empty. A decoder that priority-encodes instead of ORing would drop a request; one that merges levels would raise an empty output.
- **Latency.** `irq_lvl` is sampled before and after the one-clock peripheral edge and the two-clock external edge. A missing or extra synchronizer stage shows up as an early or late level.
- **Register port.** The bench writes all ones to the level registers, the raw status address and unmapped addresses, then reads them back. This catches unmasked upper bits and writes that leak into other registers.
- **Wake.** The wake test covers both polarities, masking, and a line mapped to the top level and then to level 0. A detector gated by the mapping, or with inverted mask or polarity sense, drives the wrong `wake_req`.

// File: rtl/ilr_pkg.sv
package ilr_pkg;
    parameter int ILR_N_PERIPH = 4;
    parameter int ILR_N_EXT    = 2;
    parameter int ILR_N_LVL    = 8;
    parameter int ILR_DATA_W   = 32;
    parameter int ILR_ADDR_W   = 4;
    parameter int ILR_EXT_BASE = 16;
endpackage

// File: rtl/ilr_sync.sv
module ilr_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d;
    end

    for (genvar k = 1; k < STAGES; k++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[k] <= '0;
            else        stg[k] <= stg[k-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/ilr_cfg.sv
module ilr_cfg #(
    parameter int N_PERIPH = 4,
    parameter int N_EXT    = 2,
    parameter int LVL_W    = 3,
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 32,
    parameter int EXT_BASE = 16,
    localparam int N_SRC   = N_PERIPH + N_EXT
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [DATA_W-1:0]      wdata,
    input  logic [N_SRC-1:0]       src,
    output logic [N_SRC*LVL_W-1:0] prio,
    output logic [N_EXT-1:0]       wmask,
    output logic [N_EXT-1:0]       wpol,
    output logic [DATA_W-1:0]      rdata
);
    localparam logic [ADDR_W-1:0] A_RAW  = ADDR_W'(N_SRC);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(N_SRC + 1);
    localparam logic [ADDR_W-1:0] A_POL  = ADDR_W'(N_SRC + 2);

    logic [LVL_W-1:0] prio_q [N_SRC];

    for (genvar s = 0; s < N_SRC; s++) begin : g_prio
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                prio_q[s] <= '0;
            else if (wr_en && addr == ADDR_W'(s))
                prio_q[s] <= wdata[LVL_W-1:0];
        end
        assign prio[s*LVL_W +: LVL_W] = prio_q[s];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wmask <= '1;
            wpol  <= '1;
        end else if (wr_en) begin
            if (addr == A_MASK) wmask <= wdata[N_EXT-1:0];
            if (addr == A_POL)  wpol  <= wdata[N_EXT-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        for (int s = 0; s < N_SRC; s++)
            if (addr == ADDR_W'(s)) rdata[LVL_W-1:0] = prio_q[s];
        if (addr == A_RAW) begin
            rdata[N_PERIPH-1:0]        = src[N_PERIPH-1:0];
            rdata[EXT_BASE +: N_EXT]   = src[N_SRC-1 -: N_EXT];
        end
        if (addr == A_MASK) rdata[N_EXT-1:0] = wmask;
        if (addr == A_POL)  rdata[N_EXT-1:0] = wpol;
    end
endmodule

// File: rtl/ilr_map.sv
module ilr_map #(
    parameter int N_SRC = 6,
    parameter int N_LVL = 8,
    parameter int LVL_W = 3
) (
    input  logic [N_SRC-1:0]       src,
    input  logic [N_SRC*LVL_W-1:0] prio,
    output logic [N_LVL-1:0]       lvl
);
    for (genvar n = 0; n < N_LVL; n++) begin : g_lvl
        logic [N_SRC-1:0] hit;
        for (genvar s = 0; s < N_SRC; s++) begin : g_src
            assign hit[s] = src[s] && (prio[s*LVL_W +: LVL_W] == LVL_W'(n));
        end
        assign lvl[n] = |hit;
    end
endmodule

// File: rtl/ilr_wake.sv
module ilr_wake #(
    parameter int N_EXT = 2
) (
    input  logic [N_EXT-1:0] ext_s,
    input  logic [N_EXT-1:0] wmask,
    input  logic [N_EXT-1:0] wpol,
    output logic             wake
);
    logic [N_EXT-1:0] at_level;
    assign at_level = ~(ext_s ^ wpol);
    assign wake     = |(at_level & ~wmask);
endmodule

// File: rtl/ilr_top.sv
module ilr_top
    import ilr_pkg::*;
#(
    parameter int N_PERIPH = ILR_N_PERIPH,
    parameter int N_EXT    = ILR_N_EXT,
    parameter int N_LVL    = ILR_N_LVL,
    parameter int DATA_W   = ILR_DATA_W,
    parameter int ADDR_W   = ILR_ADDR_W,
    parameter int EXT_BASE = ILR_EXT_BASE
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_PERIPH-1:0] irq_periph,
    input  logic [N_EXT-1:0]    ext_irq,
    input  logic                cfg_wr,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [DATA_W-1:0]   cfg_wdata,
    output logic [DATA_W-1:0]   cfg_rdata,
    output logic [N_LVL-1:0]    irq_lvl,
    output logic                wake_req
);
    localparam int N_SRC = N_PERIPH + N_EXT;
    localparam int LVL_W = $clog2(N_LVL);

    logic [N_PERIPH-1:0]    per_q;
    logic [N_EXT-1:0]       ext_s;
    logic [N_SRC-1:0]       src_q;
    logic [N_SRC*LVL_W-1:0] prio;
    logic [N_EXT-1:0]       wmask;
    logic [N_EXT-1:0]       wpol;

    ilr_sync #(.W(N_PERIPH), .STAGES(1)) u_per_reg (
        .clk(clk), .rst_n(rst_n), .d(irq_periph), .q(per_q)
    );

    ilr_sync #(.W(N_EXT), .STAGES(2)) u_ext_sync (
        .clk(clk), .rst_n(rst_n), .d(ext_irq), .q(ext_s)
    );

    assign src_q = {ext_s, per_q};

    ilr_cfg #(
        .N_PERIPH(N_PERIPH), .N_EXT(N_EXT), .LVL_W(LVL_W),
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .EXT_BASE(EXT_BASE)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .addr(cfg_addr),
        .wdata(cfg_wdata), .src(src_q), .prio(prio),
        .wmask(wmask), .wpol(wpol), .rdata(cfg_rdata)
    );

    ilr_map #(.N_SRC(N_SRC), .N_LVL(N_LVL), .LVL_W(LVL_W)) u_map (
        .src(src_q), .prio(prio), .lvl(irq_lvl)
    );

    ilr_wake #(.N_EXT(N_EXT)) u_wake (
        .ext_s(ext_s), .wmask(wmask), .wpol(wpol), .wake(wake_req)
    );
endmodule

// File: rtl/ilr_chk.sv
module ilr_chk #(
    parameter int N_PERIPH = 4,
    parameter int N_EXT    = 2,
    parameter int N_LVL    = 8,
    localparam int N_SRC   = N_PERIPH + N_EXT
) (
    input logic                clk,
    input logic                rst_n,
    input logic [N_PERIPH-1:0] irq_periph,
    input logic [N_EXT-1:0]    ext_irq,
    input logic [N_SRC-1:0]    src_q,
    input logic [N_EXT-1:0]    wmask,
    input logic [N_EXT-1:0]    wpol,
    input logic [N_LVL-1:0]    irq_lvl,
    input logic                wake_req
);
    // R1: no level is raised without an active request
    a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_lvl) |-> (|src_q));

    // R1: each request raises at most one level
    a_r1_count: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(irq_lvl) <= $countones(src_q));

    // R1: an active request always lands on some level
    a_r1_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_q) |-> (|irq_lvl));

    // R2: peripheral lines take one register stage
    a_r2_per_stage: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> src_q[N_PERIPH-1:0] == $past(irq_periph));

    // R3: external lines take two register stages
    a_r3_ext_stage: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ##1 src_q[N_SRC-1 -: N_EXT] == $past(ext_irq, 2));

    // R7: all lines masked keeps wake low
    a_r7_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (&wmask) |-> !wake_req);

    // R7 / R8: an unmasked line at its level wakes regardless of mapping
    for (genvar e = 0; e < N_EXT; e++) begin : g_wake
        a_r8_line_wakes: assert property (@(posedge clk) disable iff (!rst_n)
            (!wmask[e] && src_q[N_PERIPH+e] == wpol[e]) |-> wake_req);
    end
endmodule

bind ilr_top ilr_chk #(.N_PERIPH(N_PERIPH), .N_EXT(N_EXT), .N_LVL(N_LVL)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_periph(irq_periph), .ext_irq(ext_irq),
    .src_q(src_q), .wmask(wmask), .wpol(wpol), .irq_lvl(irq_lvl),
    .wake_req(wake_req)
);

// File: tb/ilr_top_tb.sv
module ilr_top_tb;
    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  irq_periph = '0;
    logic [1:0]  ext_irq = '0;
    logic        cfg_wr = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [7:0]  irq_lvl;
    logic        wake_req;

    int total = 0;
    int bad   = 0;
    int pr [6];

    typedef struct {
        logic [7:0] lvl;
        logic       wake;
        string      tag;
    } exp_t;
    exp_t exp_q [$];
    exp_t cur;

    always #(CLK_NS/2) clk = ~clk;

    ilr_top u_dut (
        .clk(clk), .rst_n(rst_n), .irq_periph(irq_periph), .ext_irq(ext_irq),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .irq_lvl(irq_lvl), .wake_req(wake_req)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected items and compares outputs
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            cur = exp_q.pop_front();
            chk({cur.tag, " lvl"}, {24'd0, irq_lvl}, {24'd0, cur.lvl});
            chk({cur.tag, " wake"}, {31'd0, wake_req}, {31'd0, cur.wake});
        end
    end

    function automatic logic [7:0] model_lvl(logic [3:0] p, logic [1:0] e);
        logic [5:0] s;
        logic [7:0] r;
        s = {e, p};
        r = '0;
        for (int i = 0; i < 6; i++) if (s[i]) r[pr[i]] = 1'b1;
        return r;
    endfunction

    task automatic drive(logic [3:0] p, logic [1:0] e, logic wk, string tag);
        exp_t it;
        @(negedge clk);
        irq_periph = p;
        ext_irq    = e;
        repeat (3) @(posedge clk);
        it.lvl  = model_lvl(p, e);
        it.wake = wk;
        it.tag  = tag;
        exp_q.push_back(it);
        @(negedge clk);
        #1;
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        cfg_addr  = a;
        cfg_wdata = d;
        cfg_wr    = 1'b1;
        @(negedge clk);
        cfg_wr    = 1'b0;
    endtask

    task automatic set_prio(int i, int v);
        wr(4'(i), 32'(v));
        pr[i] = v;
    endtask

    task automatic rd_chk(logic [3:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        cfg_addr = a;
        #2;
        chk(tag, cfg_rdata, exp);
    endtask

    initial begin
        #(CLK_NS * 100000);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 6; i++) pr[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R10 / R4 / R6 reset state
        #1;
        chk("R10 lvl reset", {24'd0, irq_lvl}, 32'd0);
        chk("R10 wake reset", {31'd0, wake_req}, 32'd0);
        rd_chk(4'd6, 32'd0, "R10 raw reset");
        for (int i = 0; i < 6; i++) rd_chk(4'(i), 32'd0, "R4 prio reset");
        rd_chk(4'd7, 32'd3, "R6 mask reset");
        rd_chk(4'd8, 32'd3, "R6 pol reset");

        // R1 default mapping to level 0
        drive(4'b0100, 2'b00, 1'b0, "R1 default level0");
        drive(4'b0000, 2'b11, 1'b0, "R1 ext level0 masked");

        // R1 distinct levels 1..6
        for (int i = 0; i < 6; i++) set_prio(i, i + 1);
        for (int i = 0; i < 6; i++)
            drive(4'((1 << i) & 15), 2'((1 << i) >> 4), 1'b0, "R1 single source");
        drive(4'b1111, 2'b11, 1'b0, "R1 all sources empty levels");

        // R1 shared level
        set_prio(4, 1);
        drive(4'b0001, 2'b01, 1'b0, "R1 shared level");
        drive(4'b0000, 2'b01, 1'b0, "R1 shared level ext only");

        // R5 raw status independent of mapping
        drive(4'b1010, 2'b01, 1'b0, "R5 setup");
        rd_chk(4'd6, 32'h0001_000A, "R5 raw status");
        set_prio(1, 7);
        rd_chk(4'd6, 32'h0001_000A, "R5 raw after remap");

        // R9 ignored writes
        wr(4'd6, 32'hFFFF_FFFF);
        rd_chk(4'd6, 32'h0001_000A, "R9 raw write ignored");
        wr(4'd12, 32'hFFFF_FFFF);
        rd_chk(4'd12, 32'd0, "R9 unmapped reads zero");
        rd_chk(4'd0, 32'd1, "R9 prio0 untouched");
        rd_chk(4'd7, 32'd3, "R9 mask untouched");

        // R4 only low 3 bits kept
        wr(4'd5, 32'hFFFF_FFFF);
        pr[5] = 7;
        rd_chk(4'd5, 32'd7, "R4 prio width");

        // R2 peripheral latency (prio0 = 1)
        drive(4'b0000, 2'b00, 1'b0, "R2 idle");
        irq_periph = 4'b0001;
        #1;
        chk("R2 no comb path", {24'd0, irq_lvl}, 32'd0);
        @(negedge clk);
        chk("R2 one clock", {24'd0, irq_lvl}, 32'h02);
        irq_periph = 4'b0000;
        @(negedge clk);

        // R3 external latency (prio4 = 1)
        ext_irq = 2'b01;
        @(negedge clk);
        chk("R3 after one clock", {24'd0, irq_lvl}, 32'd0);
        @(negedge clk);
        chk("R3 after two clocks", {24'd0, irq_lvl}, 32'h02);
        drive(4'b0000, 2'b00, 1'b0, "R3 idle");

        // R7 wake polarity and mask
        wr(4'd7, 32'h2);
        drive(4'b0000, 2'b01, 1'b1, "R7 ext0 high wakes");
        drive(4'b0000, 2'b00, 1'b0, "R7 ext0 low quiet");
        wr(4'd8, 32'h2);
        drive(4'b0000, 2'b00, 1'b1, "R7 active low wakes");
        drive(4'b0000, 2'b01, 1'b0, "R7 active low quiet");
        wr(4'd7, 32'h3);
        drive(4'b0000, 2'b00, 1'b0, "R6 masked quiet");

        // R8 wake independent of mapping (ext1 on level 7, then 0)
        wr(4'd8, 32'h3);
        wr(4'd7, 32'h1);
        drive(4'b0000, 2'b10, 1'b1, "R8 ext1 level7 wakes");
        set_prio(5, 0);
        drive(4'b0000, 2'b10, 1'b1, "R8 ext1 level0 wakes");
        drive(4'b0000, 2'b01, 1'b0, "R8 ext0 masked quiet");

        wait (exp_q.size() == 0);
        @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule